// File: doc/BRIEF.md
# Burst Page-Mode ROM Read Controller

This block sits between a simple on-chip requester and an asynchronous ROM that supports page-mode reads. A request carries an address, a read/write flag and a burst flag, and it is launched by a one-cycle start strobe. The controller drives the chip select, the read and write strobes, a bus-start strobe and the address bus. It returns each word it reads with a one-cycle valid pulse, and it signals the end of the transfer with a done pulse.

A burst read holds the read strobe low across four beats on a 32-bit bus. Only the address moves from one beat to the next. The first beat follows normal timing: it uses a long wait count, asserts the bus-start strobe and can be stretched by the external wait input. The three later beats use a short wait count of their own and do not react to the external wait. A single read, or any write, is one normal beat, after which the strobes are released.

Top module: `pagerom_ctrl`

## Requirements
- R1: A request is accepted on a rising edge where `req_start` is high and the block is idle. From the following cycle, `mem_cs_n` and `mem_bs_n` are low, together with `mem_rd_n` for a read, or with `mem_wr_n` and `mem_oe` for a write.
- R2: The first beat lasts `cfg_first_wait`+1 clock cycles (`cfg_first_wait` is 0 to 15) while the synchronized wait is low.
- R3: Each later burst beat lasts `cfg_burst_wait`+1 cycles (0 to 3). `mem_rd_n` stays low between beats, and `mem_bs_n` is high for every beat after the first.
- R4: Beat addresses keep the request's address above bit 4 and its bits 1:0. Bits 3:2 start at the request value and increase by one per beat, wrapping inside the 16-byte page. `mem_addr` changes on the falling clock edge.
- R5: Read data is captured on the rising edge that ends each beat. In the next cycle `rsp_valid` is high for one cycle and `rsp_rdata` holds the word. A burst gives exactly four valid pulses.
- R6: `mem_wait` goes through a two-flop synchronizer. While it is high, the first beat holds at its final cycle. The input is ignored during later burst beats.
- R7: `rsp_done` pulses in the cycle after the last beat ends, which is the same cycle as the last valid pulse of a read. In that cycle every strobe is released. Chip select then stays high for at least two cycles, and `req_start` is ignored while a transfer or the gap is in progress.
- R8: A single read or a write is one first-access beat. A write is never bursted, drives `mem_wdata` with `mem_oe` high, and produces no valid pulse. The read and write strobes are never low together.
- R9: While `rst_n` is low, all strobes are high, `mem_oe`, `rsp_valid` and `rsp_done` are low, and `mem_addr` is zero.
- R10: Both wait fields are sampled when the request is accepted. Changing them during the transfer has no effect on it.
- R11: A wait field of zero gives a one-cycle beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Request a four-beat burst read |
| req_addr | input | AW | Byte address of the first beat |
| req_wdata | input | DW | Write data |
| cfg_first_wait | input | FWW | Wait cycles for the first beat |
| cfg_burst_wait | input | BWW | Wait cycles for each later beat |
| rsp_valid | output | 1 | Read word valid pulse |
| rsp_rdata | output | DW | Captured read word |
| rsp_done | output | 1 | Transfer complete pulse |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_bs_n | output | 1 | Bus-start strobe, active low |
| mem_oe | output | 1 | Data bus drive enable for writes |
| mem_addr | output | AW | Memory address, updated on falling edge |
| mem_wdata | output | DW | Data driven onto the bus |
| mem_rdata | input | DW | Data returned by the ROM |
| mem_wait | input | 1 | External wait, asynchronous, active high |

## Verification
Two events can fall in the same cycle. The final burst word's valid pulse always coincides with the done pulse and the release of every strobe. A late arrival of the synchronized wait can also meet the last cycle of the first-beat countdown. The bench holds `mem_wait` high through the start of a burst and releases it a set number of cycles later. It also raises `mem_wait` right after the first valid word of another burst. A behavioural model predicts every pin on every clock, and measured latencies are compared with the closed-form beat sums. That comparison shows where the hold ended and confirms that later beats did not stretch.

// File: rtl/pagerom_pkg.sv
// Shared types for the page-mode ROM controller.
// Assumes active-low strobes on the memory side.
package pagerom_pkg;

    typedef enum logic [1:0] {
        PR_IDLE  = 2'd0,
        PR_LEAD  = 2'd1,
        PR_TRAIL = 2'd2,
        PR_GAP   = 2'd3
    } pr_state_e;

    typedef struct packed {
        logic cs_n;
        logic rd_n;
        logic wr_n;
        logic bs_n;
        logic oe;
    } pr_pins_t;

    localparam pr_pins_t PINS_QUIET = '{cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, bs_n: 1'b1, oe: 1'b0};

endpackage

// File: rtl/pagerom_sync.sv
// Multi-stage synchronizer for an asynchronous level input.
// Assumes STAGES >= 2; output lags the input by STAGES rising edges.
module pagerom_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d};
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/pagerom_beat_timer.sv
// Down-counter that times one beat; expired is high in the beat's final cycle.
// Assumes load and run are never needed in the same cycle for different beats.
module pagerom_beat_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    // Load a fresh wait count or step toward zero, then rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (load)                cnt_q <= load_val;
        else if (run && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pagerom_addr_gen.sv
// Beat address generator with in-page wrap and falling-edge output register.
// Assumes BEATS words fill one aligned page; index bits sit just above the byte offset.
module pagerom_addr_gen #(
    parameter int AW   = 24,
    parameter int OFS  = 2,
    parameter int IDXW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base,
    input  logic          step,
    output logic [AW-1:0] addr_out
);
    localparam int HIW = AW - OFS - IDXW;

    logic [HIW-1:0]  hi_q;
    logic [IDXW-1:0] idx_q;
    logic [OFS-1:0]  lo_q;
    logic [AW-1:0]   beat_addr;

    // Capture the page and start index; advance the index inside the page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q  <= '0;
            idx_q <= '0;
            lo_q  <= '0;
        end else if (start) begin
            hi_q  <= base[AW-1:OFS+IDXW];
            idx_q <= base[OFS+IDXW-1:OFS];
            lo_q  <= base[OFS-1:0];
        end else if (step) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign beat_addr = {hi_q, idx_q, lo_q};

    // Present the beat address to the ROM half a cycle later, on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) addr_out <= '0;
        else        addr_out <= beat_addr;
    end
endmodule

// File: rtl/pagerom_ctrl.sv
// Page-mode ROM controller: single reads/writes with normal timing, and
// fixed-length burst reads holding the read strobe while the address moves.
// Assumes BEATS is a power of two >= 2 and DW is a multiple of 8.
module pagerom_ctrl
    import pagerom_pkg::*;
#(
    parameter int AW    = 24,
    parameter int DW    = 32,
    parameter int BEATS = 4,
    parameter int FWW   = 4,
    parameter int BWW   = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_start,
    input  logic           req_write,
    input  logic           req_burst,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_wdata,
    input  logic [FWW-1:0] cfg_first_wait,
    input  logic [BWW-1:0] cfg_burst_wait,
    output logic           rsp_valid,
    output logic [DW-1:0]  rsp_rdata,
    output logic           rsp_done,
    output logic           mem_cs_n,
    output logic           mem_rd_n,
    output logic           mem_wr_n,
    output logic           mem_bs_n,
    output logic           mem_oe,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           mem_wait
);
    localparam int OFS  = $clog2(DW / 8);
    localparam int IDXW = $clog2(BEATS);
    localparam int CW   = (FWW > BWW) ? FWW : BWW;

    pr_state_e       state_q;
    pr_pins_t        pins_q;
    logic [IDXW-1:0] beat_q;
    logic            write_q;
    logic            burst_q;
    logic [BWW-1:0]  bwait_q;
    logic [DW-1:0]   rdata_q;
    logic [DW-1:0]   wdata_q;
    logic            valid_q;
    logic            done_q;

    logic            wait_s;
    logic            expired;
    logic            accept;
    logic            active;
    logic            beat_end;
    logic            last_beat;
    logic            step;
    logic [CW-1:0]   load_val;

    pagerom_sync #(.STAGES(2)) u_wait_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (mem_wait),
        .q     (wait_s)
    );

    assign accept    = (state_q == PR_IDLE) && req_start;
    assign active    = (state_q == PR_LEAD) || (state_q == PR_TRAIL);
    assign beat_end  = active && expired && !((state_q == PR_LEAD) && wait_s);
    assign last_beat = !burst_q || (beat_q == IDXW'(BEATS - 1));
    assign step      = beat_end && !last_beat;
    assign load_val  = accept ? CW'(cfg_first_wait) : CW'(bwait_q);

    pagerom_beat_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept || step),
        .load_val (load_val),
        .run      (active),
        .expired  (expired)
    );

    pagerom_addr_gen #(.AW(AW), .OFS(OFS), .IDXW(IDXW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .base     (req_addr),
        .step     (step),
        .addr_out (mem_addr)
    );

    // Sequence the transfer: accept, first beat, later beats, idle gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PR_IDLE;
            pins_q  <= PINS_QUIET;
            beat_q  <= '0;
            write_q <= 1'b0;
            burst_q <= 1'b0;
            bwait_q <= '0;
            rdata_q <= '0;
            wdata_q <= '0;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            unique case (state_q)
                PR_IDLE: begin
                    if (req_start) begin
                        state_q     <= PR_LEAD;
                        pins_q.cs_n <= 1'b0;
                        pins_q.bs_n <= 1'b0;
                        pins_q.rd_n <= req_write;
                        pins_q.wr_n <= !req_write;
                        pins_q.oe   <= req_write;
                        write_q     <= req_write;
                        burst_q     <= req_burst && !req_write;
                        bwait_q     <= cfg_burst_wait;
                        wdata_q     <= req_wdata;
                        beat_q      <= '0;
                    end
                end
                PR_LEAD, PR_TRAIL: begin
                    if (beat_end) begin
                        if (!write_q) begin
                            rdata_q <= mem_rdata;
                            valid_q <= 1'b1;
                        end
                        if (last_beat) begin
                            state_q <= PR_GAP;
                            pins_q  <= PINS_QUIET;
                            done_q  <= 1'b1;
                        end else begin
                            state_q     <= PR_TRAIL;
                            pins_q.bs_n <= 1'b1;
                            beat_q      <= beat_q + 1'b1;
                        end
                    end
                end
                PR_GAP: state_q <= PR_IDLE;
                default: state_q <= PR_IDLE;
            endcase
        end
    end

    assign mem_cs_n  = pins_q.cs_n;
    assign mem_rd_n  = pins_q.rd_n;
    assign mem_wr_n  = pins_q.wr_n;
    assign mem_bs_n  = pins_q.bs_n;
    assign mem_oe    = pins_q.oe;
    assign mem_wdata = wdata_q;
    assign rsp_rdata = rdata_q;
    assign rsp_valid = valid_q;
    assign rsp_done  = done_q;
endmodule

// File: rtl/pagerom_ctrl_chk.sv
// Protocol checker for pagerom_ctrl, attached by bind.
// Assumes only the top-level pins are visible.
module pagerom_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic mem_cs_n,
    input logic mem_rd_n,
    input logic mem_wr_n,
    input logic mem_bs_n,
    input logic rsp_valid,
    input logic rsp_done
);
    p_strobe_in_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n || !mem_wr_n || !mem_bs_n) |-> !mem_cs_n);

    p_bs_on_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cs_n) |-> !mem_bs_n);

    p_rd_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !mem_cs_n) |-> (!mem_rd_n && mem_bs_n));

    p_done_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (mem_cs_n && mem_rd_n && mem_wr_n && mem_bs_n));

    p_gap_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> mem_cs_n);

    p_no_rd_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && !mem_wr_n));

    p_no_valid_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |=> !rsp_valid);
endmodule

bind pagerom_ctrl pagerom_ctrl_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_cs_n  (mem_cs_n),
    .mem_rd_n  (mem_rd_n),
    .mem_wr_n  (mem_wr_n),
    .mem_bs_n  (mem_bs_n),
    .rsp_valid (rsp_valid),
    .rsp_done  (rsp_done)
);

// File: tb/test_pagerom_ctrl.sv
// Bench: behavioural per-clock model compared on every cycle, plus latency checks.
module test_pagerom_ctrl;
    localparam int AW = 24;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_start = 1'b0, req_write = 1'b0, req_burst = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [3:0]    cfg_first_wait = '0;
    logic [1:0]    cfg_burst_wait = '0;
    logic          mem_wait = 1'b0;
    logic          rsp_valid, rsp_done, mem_cs_n, mem_rd_n, mem_wr_n, mem_bs_n, mem_oe;
    logic [DW-1:0] rsp_rdata, mem_wdata, mem_rdata;
    logic [AW-1:0] mem_addr;

    int n_tests = 0, n_fail = 0, cyc = 0;
    string scen = "reset";

    function automatic logic [31:0] romword(input logic [AW-1:0] a);
        return 32'hC0DE_0000 ^ {8'h5A, a};
    endfunction

    assign mem_rdata = romword(mem_addr);

    pagerom_ctrl i_pagerom_ctrl (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
        .req_burst(req_burst), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_first_wait(cfg_first_wait), .cfg_burst_wait(cfg_burst_wait),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
        .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .mem_bs_n(mem_bs_n), .mem_oe(mem_oe), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_wait(mem_wait)
    );

    always #4 clk = ~clk;

    // Model state
    int ph = 0, beat = 0, left = 0, bw = 0;
    bit m_wr = 0, m_bu = 0, w1 = 0, w2 = 0;
    logic [AW-1:0] m_addr = '0;
    bit e_cs = 1, e_rd = 1, e_wr = 1, e_bs = 1, e_oe = 0, e_valid = 0, e_done = 0;
    logic [31:0] e_rdata = '0, e_wdata = '0;

    always @(posedge clk) begin
        bit endb;
        cyc++;
        e_valid = 0; e_done = 0;
        if (!rst_n) begin
            ph = 0; beat = 0; left = 0; bw = 0; m_wr = 0; m_bu = 0; w1 = 0; w2 = 0;
            m_addr = '0; e_cs = 1; e_rd = 1; e_wr = 1; e_bs = 1; e_oe = 0;
            e_rdata = '0; e_wdata = '0;
        end else begin
            case (ph)
                0: if (req_start) begin
                    ph = 1; beat = 0; m_wr = req_write; m_bu = req_burst && !req_write;
                    left = cfg_first_wait; bw = cfg_burst_wait; m_addr = req_addr;
                    e_wdata = req_wdata; e_cs = 0; e_bs = 0; e_rd = req_write;
                    e_wr = !req_write; e_oe = req_write;
                end
                1, 3: begin
                    endb = (left == 0) && !(ph == 1 && w2);
                    if (endb) begin
                        if (!m_wr) begin e_rdata = romword(m_addr); e_valid = 1; end
                        if (!m_bu || beat == 3) begin
                            ph = 2; e_cs = 1; e_rd = 1; e_wr = 1; e_bs = 1; e_oe = 0; e_done = 1;
                        end else begin
                            ph = 3; beat++; e_bs = 1; left = bw;
                            m_addr[3:2] = m_addr[3:2] + 2'd1;
                        end
                    end else if (left > 0) left--;
                end
                default: ph = 0;
            endcase
            w2 = w1; w1 = mem_wait;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s [%s]: actual %h expected %h", tag, scen, act, exp);
        end
    endtask

    // Monitors measured from the ports
    bit prev_cs = 1, lat_seen = 0;
    int t_acc = 0, lat = 0, n_valid = 0, n_done = 0, hi_run = 0, last_hi_run = 0;

    always @(posedge clk) begin
        #6;
        chk("R1 cs_n", mem_cs_n, e_cs);
        chk("R3 rd_n", mem_rd_n, e_rd);
        chk("R8 wr_n", mem_wr_n, e_wr);
        chk("R3 bs_n", mem_bs_n, e_bs);
        chk("R8 oe", mem_oe, e_oe);
        chk("R4 addr", mem_addr, m_addr);
        chk("R5 valid", rsp_valid, e_valid);
        chk("R7 done", rsp_done, e_done);
        if (e_valid) chk("R5 rdata", rsp_rdata, e_rdata);
        if (e_oe) chk("R8 wdata", mem_wdata, e_wdata);
        if (prev_cs && !mem_cs_n) begin t_acc = cyc; last_hi_run = hi_run; end
        hi_run = mem_cs_n ? hi_run + 1 : 0;
        if (rsp_done) begin lat = cyc - t_acc; lat_seen = 1; n_done++; end
        if (rsp_valid) n_valid++;
        prev_cs = mem_cs_n;
    end

    task automatic txn(input logic [AW-1:0] a, input bit w, input bit b, input logic [31:0] wd,
                       input logic [3:0] fw, input logic [1:0] bwv, input string sc);
        scen = sc; cfg_first_wait = fw; cfg_burst_wait = bwv;
        req_addr = a; req_write = w; req_burst = b; req_wdata = wd;
        lat_seen = 0; n_valid = 0; req_start = 1;
        @(posedge clk); #2 req_start = 0;
        while (!lat_seen) begin @(posedge clk); #2; end
        repeat (3) @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #6;
        chk("R9 reset cs_n", mem_cs_n, 1);
        chk("R9 reset strobes", {mem_rd_n, mem_wr_n, mem_bs_n}, 3'b111);
        chk("R9 reset outs", {mem_oe, rsp_valid, rsp_done}, 3'b000);
        chk("R9 reset addr", mem_addr, 0);
        #4 rst_n = 1'b1;
        @(posedge clk); #2;

        txn(24'h000104, 0, 0, 0, 4'd0, 2'd0, "R11 single zero wait");
        chk("R11 latency", lat, 1);
        chk("R8 single valids", n_valid, 1);

        txn(24'h00A010, 0, 0, 0, 4'd5, 2'd3, "R2 single wait5");
        chk("R2 latency", lat, 6);

        txn(24'h000208, 1, 1, 32'hDEAD_BEEF, 4'd2, 2'd3, "R8 write");
        chk("R8 write latency", lat, 3);
        chk("R8 write valids", n_valid, 0);

        txn(24'h123438, 0, 1, 0, 4'd2, 2'd1, "R4 burst wrap");
        chk("R3 burst latency", lat, 9);
        chk("R5 burst valids", n_valid, 4);

        txn(24'h000300, 0, 1, 0, 4'd0, 2'd0, "R11 burst zero waits");
        chk("R11 burst latency", lat, 4);

        txn(24'h0FFF34, 0, 1, 0, 4'd15, 2'd3, "R3 burst max waits");
        chk("R3 max latency", lat, 28);

        mem_wait = 1;
        repeat (3) @(posedge clk);
        #2;
        fork
            txn(24'h000400, 0, 1, 0, 4'd1, 2'd0, "R6 wait hold");
            begin repeat (6) @(posedge clk); #2 mem_wait = 0; end
        join
        chk("R6 held latency", lat, 11);

        fork
            txn(24'h000504, 0, 1, 0, 4'd0, 2'd2, "R6 wait ignored");
            begin @(posedge rsp_valid); #1 mem_wait = 1; end
        join
        chk("R6 ignored latency", lat, 10);
        mem_wait = 0;
        repeat (3) @(posedge clk);
        #2;

        fork
            txn(24'h00060C, 0, 1, 0, 4'd1, 2'd1, "R7 start while busy");
            begin repeat (2) @(posedge clk); #2 req_start = 1; repeat (4) @(posedge clk); #2 req_start = 0; end
        join
        chk("R7 busy latency", lat, 8);
        chk("R7 busy valids", n_valid, 4);

        scen = "R7 back to back";
        cfg_first_wait = 0; cfg_burst_wait = 0; req_write = 0; req_burst = 1;
        req_addr = 24'h000700; n_done = 0; req_start = 1;
        while (n_done < 2) begin @(posedge clk); #2; end
        req_start = 0;
        repeat (6) @(posedge clk);
        #2;
        chk("R7 cs high gap", last_hi_run, 2);

        fork
            txn(24'h000814, 0, 1, 0, 4'd1, 2'd1, "R10 cfg change");
            begin @(posedge clk); #3 cfg_burst_wait = 3; cfg_first_wait = 9; end
        join
        chk("R10 latency", lat, 8);

        finish_run();
    end
endmodule